// File: doc/BRIEF.md
# Staged Power Switch Ramp Controller

This block drives the 8-bit control word of one core's power switch. Each bit enables one segment of the switch, and a set bit keeps that segment off. When the block opens the domain, it turns the segments on in stages. This limits the inrush current that the supply would see if every segment turned on at once. Closing the domain needs no such care, so the block turns every segment off in one step.

An open request starts a five-value ramp from the closed word to the open word. Each value is held for a dwell of `DWELL_CYCLES` clock cycles, which the integrator derives from the clock frequency (10 us at the target clock). A close request drives the closed word and waits one dwell. While a sequence runs, `busy` is high and every request is ignored. A single-cycle `done` pulse marks the end of each sequence. An open request that arrives while the switch is already fully open starts no ramp and is acknowledged with `done` alone.

Top module: `pwr_ramp_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `sw_word` is 0xFF (all segments off), `busy` is 0 and `done` is 0.
- R2: An accepted open request from a word other than 0x00 drives `sw_word` through 0xFF, 0xFE, 0xF8, 0xF0, 0x00, in that order. The first value appears in the cycle after the request.
- R3: Each value of the open ramp is held for exactly `DWELL_CYCLES` cycles, and `busy` is 1 for all of them.
- R4: When a sequence finishes, `busy` falls and `done` is 1 for exactly one cycle. For an open ramp this is `5*DWELL_CYCLES` cycles after the first ramp value appears. `done` and `busy` are never 1 together.
- R5: An open request while `sw_word` is 0x00 leaves the word at 0x00 and keeps `busy` at 0. It gives a `done` pulse in the next cycle.
- R6: An accepted close request drives 0xFF in the next cycle, holds `busy` for `DWELL_CYCLES` cycles, and then pulses `done`.
- R7: Open or close requests that arrive while `busy` is 1 have no effect on `sw_word`, `busy` or `done`.
- R8: When open and close are requested in the same idle cycle, the close is performed.
- R9: `sw_word` changes only in cycles where `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| open_req | input | 1 | Request to open the power domain (sampled when idle) |
| close_req | input | 1 | Request to close the power domain (sampled when idle) |
| sw_word | output | 8 | Power switch control word; 0xFF closed, 0x00 open |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The bench goes after the dwell boundaries of every ramp value. A counter that is off by one would shift each later value by a cycle and misplace the `done` pulse. It repeats an open request on an already open switch. A design that missed this case would ramp the switch back through 0xFF and cause a brief power loss. The bench also sends noise requests during a ramp and a simultaneous open and close. A design that listened while busy would cut the ramp short or restart it. A design with the wrong priority would open the domain when the caller asked for it to be closed.

// File: rtl/pwr_ramp_pkg.sv
package pwr_ramp_pkg;
  localparam int WORD_W    = 8;
  localparam int NUM_STEPS = 5;
  localparam int IDX_W     = $clog2(NUM_STEPS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STEPS - 1);
  localparam logic [WORD_W-1:0] WORD_CLOSED = 8'hFF;
  localparam logic [WORD_W-1:0] WORD_OPEN   = 8'h00;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_OPEN  = 2'd1,
    PH_CLOSE = 2'd2
  } ramp_phase_t;

  // Switch word driven at each stage of the opening ramp.
  function automatic logic [WORD_W-1:0] ramp_value(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    ramp_value = 8'hFF;
      3'd1:    ramp_value = 8'hFE;
      3'd2:    ramp_value = 8'hF8;
      3'd3:    ramp_value = 8'hF0;
      default: ramp_value = 8'h00;
    endcase
  endfunction

  // Successor of a word along the opening ramp (used by checks).
  function automatic logic [WORD_W-1:0] ramp_successor(input logic [WORD_W-1:0] w);
    case (w)
      8'hFF:   ramp_successor = 8'hFE;
      8'hFE:   ramp_successor = 8'hF8;
      8'hF8:   ramp_successor = 8'hF0;
      8'hF0:   ramp_successor = 8'h00;
      default: ramp_successor = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/pwr_ramp_dwell.sv
module pwr_ramp_dwell #(
  parameter int DWELL_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expire
);
  localparam int CNT_W = $clog2(DWELL_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DWELL_CYCLES - 1);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= RELOAD;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expire = (remain_q == '0);
endmodule

// File: rtl/pwr_ramp_fsm.sv
module pwr_ramp_fsm
  import pwr_ramp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              open_req,
  input  logic              close_req,
  input  logic              expire,
  output logic              load,
  output logic [WORD_W-1:0] word_q,
  output logic              busy_q,
  output logic              done_q
);
  ramp_phase_t      phase_q;
  logic [IDX_W-1:0] idx_q;

  logic take_close, take_open, ramp_needed;

  assign take_close  = (phase_q == PH_IDLE) && close_req;
  assign take_open   = (phase_q == PH_IDLE) && !close_req && open_req;
  assign ramp_needed = (word_q != WORD_OPEN);

  // Restart the dwell on every newly driven word.
  assign load = take_close
              || (take_open && ramp_needed)
              || ((phase_q == PH_OPEN) && expire && (idx_q != LAST_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      word_q  <= WORD_CLOSED;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (take_close) begin
            word_q  <= WORD_CLOSED;
            phase_q <= PH_CLOSE;
            busy_q  <= 1'b1;
          end else if (take_open) begin
            if (ramp_needed) begin
              idx_q   <= '0;
              word_q  <= ramp_value('0);
              phase_q <= PH_OPEN;
              busy_q  <= 1'b1;
            end else begin
              done_q <= 1'b1;
            end
          end
        end
        PH_OPEN: begin
          if (expire) begin
            if (idx_q == LAST_IDX) begin
              phase_q <= PH_IDLE;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              idx_q  <= idx_q + 1'b1;
              word_q <= ramp_value(idx_q + 1'b1);
            end
          end
        end
        PH_CLOSE: begin
          if (expire) begin
            phase_q <= PH_IDLE;
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          busy_q  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pwr_ramp_ctrl.sv
module pwr_ramp_ctrl
  import pwr_ramp_pkg::*;
#(
  parameter int DWELL_CYCLES = 1250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_req,
  input  logic              close_req,
  output logic [WORD_W-1:0] sw_word,
  output logic              busy,
  output logic              done
);
  logic load, expire;

  pwr_ramp_dwell #(.DWELL_CYCLES(DWELL_CYCLES)) u_dwell (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .expire (expire)
  );

  pwr_ramp_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .open_req  (open_req),
    .close_req (close_req),
    .expire    (expire),
    .load      (load),
    .word_q    (sw_word),
    .busy_q    (busy),
    .done_q    (done)
  );
endmodule

// File: rtl/pwr_ramp_chk.sv
module pwr_ramp_chk
  import pwr_ramp_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              open_req,
  input logic              close_req,
  input logic [WORD_W-1:0] sw_word,
  input logic              busy,
  input logic              done
);
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  a_r9_word_frozen_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> $stable(sw_word));

  a_r2_step_order: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (sw_word != $past(sw_word)))
      |-> (sw_word == ramp_successor($past(sw_word))));

  a_r6_close_first: assert property (@(posedge clk) disable iff (rst)
    (!busy && close_req) |=> (busy && sw_word == WORD_CLOSED));

  a_r5_open_noop: assert property (@(posedge clk) disable iff (rst)
    (!busy && open_req && !close_req && sw_word == WORD_OPEN)
      |=> (done && !busy && sw_word == WORD_OPEN));
endmodule

bind pwr_ramp_ctrl pwr_ramp_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .open_req  (open_req),
  .close_req (close_req),
  .sw_word   (sw_word),
  .busy      (busy),
  .done      (done)
);

// File: tb/pwr_ramp_ctrl_test.sv
module pwr_ramp_ctrl_test;
  localparam int D = 4;

  typedef struct {
    logic [7:0] word;
    logic       busy;
    logic       done;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       open_req = 1'b0;
  logic       close_req = 1'b0;
  logic [7:0] sw_word;
  logic       busy, done;

  int   total = 0;
  int   bad = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  pwr_ramp_ctrl #(.DWELL_CYCLES(D)) uut (
    .clk(clk), .rst(rst), .open_req(open_req), .close_req(close_req),
    .sw_word(sw_word), .busy(busy), .done(done)
  );

  function automatic logic [7:0] ramp_at(int k);
    case (k)
      0: ramp_at = 8'hFF;
      1: ramp_at = 8'hFE;
      2: ramp_at = 8'hF8;
      3: ramp_at = 8'hF0;
      default: ramp_at = 8'h00;
    endcase
  endfunction

  task automatic push(logic [7:0] w, logic b, logic d, string tag);
    exp_t e;
    e.word = w; e.busy = b; e.done = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_open_ramp();
    for (int j = 0; j < 5 * D; j++) push(ramp_at(j / D), 1'b1, 1'b0, "R2 R3 ramp");
    push(8'h00, 1'b0, 1'b1, "R4 done after ramp");
    push(8'h00, 1'b0, 1'b0, "R4 done single");
  endtask

  task automatic push_close();
    for (int j = 0; j < D; j++) push(8'hFF, 1'b1, 1'b0, "R6 close dwell");
    push(8'hFF, 1'b0, 1'b1, "R6 close done");
    push(8'hFF, 1'b0, 1'b0, "R6 done single");
  endtask

  // kind: 0 open ramp, 1 close, 2 open on open switch
  task automatic stim(bit o, bit c, int kind);
    @(negedge clk);
    case (kind)
      0: push_open_ramp();
      1: push_close();
      default: begin
        push(8'h00, 1'b0, 1'b1, "R5 done on open switch");
        push(8'h00, 1'b0, 1'b0, "R5 stays open");
      end
    endcase
    open_req = o; close_req = c;
    @(negedge clk);
    open_req = 1'b0; close_req = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: compares outputs shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (sw_word !== e.word || busy !== e.busy || done !== e.done) begin
          bad++;
          $display("FAIL %s: got word=%h busy=%b done=%b exp word=%h busy=%b done=%b",
                   e.tag, sw_word, busy, done, e.word, e.busy, e.done);
        end
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got hang exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (sw_word !== 8'hFF || busy !== 1'b0 || done !== 1'b0) begin
      bad++;
      $display("FAIL R1 in reset: got %h %b %b exp ff 0 0", sw_word, busy, done);
    end
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (sw_word !== 8'hFF || busy !== 1'b0 || done !== 1'b0) begin
      bad++;
      $display("FAIL R1 after reset: got %h %b %b exp ff 0 0", sw_word, busy, done);
    end

    stim(1'b1, 1'b0, 0); drain();       // R2 R3 R4 ramp from closed
    stim(1'b1, 1'b0, 2); drain();       // R5 already open
    stim(1'b0, 1'b1, 1); drain();       // R6 close from open
    stim(1'b0, 1'b1, 1); drain();       // R6 close from closed

    // R7: requests during a ramp are ignored
    stim(1'b1, 1'b0, 0);
    @(negedge clk); open_req = 1'b1; close_req = 1'b1;
    @(negedge clk); open_req = 1'b0; close_req = 1'b0;
    repeat (D) @(negedge clk);
    close_req = 1'b1;
    @(negedge clk); close_req = 1'b0;
    drain();

    // R7: requests during a close are ignored
    stim(1'b0, 1'b1, 1);
    @(negedge clk); open_req = 1'b1;
    @(negedge clk); open_req = 1'b0;
    drain();

    stim(1'b1, 1'b0, 0); drain();       // reopen
    stim(1'b1, 1'b1, 1); drain();       // R8 close wins
    stim(1'b1, 1'b1, 1); drain();       // R8 again from closed

    // R9: word holds while idle
    repeat (5) begin
      @(negedge clk);
      total++;
      if (sw_word !== 8'hFF || busy !== 1'b0) begin
        bad++;
        $display("FAIL R9 idle hold: got %h %b exp ff 0", sw_word, busy);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule